// File: doc/BRIEF.md
# Write-Update Snooping Coherence Line Controller

This block holds one cache line (address tag, data word and coherence state) and keeps it coherent on a shared bus under a write-update protocol. A valid line is in one of three states: exclusive-clean (the only cached copy, equal to memory), shared (other caches may hold copies), or dirty (the only copy, newer than memory). Processor reads and writes arrive on a request channel. The block decides whether it can serve them locally or must issue a bus command. When a write hits a shared line, every other copy and memory receive the new value, and no copy is invalidated.

Bus traffic from other caches is presented on a snoop port. When the snooped address matches a valid line, the block reports that it holds a copy. For a snooped block read it also supplies its data, and it flags a flush to memory if the line was dirty. For a snooped block write or update it takes the broadcast value. In all three cases the line ends shared. A miss replaces the line outright, and the caller handles any victim.

Back-pressure rules are as follows. A processor request transfers on a cycle where both `cpu_req_valid` and `cpu_req_ready` are high, and only one request is outstanding at a time. The response holds `cpu_rsp_valid` and its data steady until `cpu_rsp_ready` is high. A bus command holds valid, opcode, address and data steady until `bus_cmd_ready` grants it. After the grant, the bus returns `bus_done` for one cycle, with `bus_shared_in` (another cache holds the line) and `bus_rdata`. `bus_done` never coincides with `snp_valid`.

Top module: `upd_coh_line`

## Requirements
- R1: After reset the line state reads 0 (invalid), `cpu_req_ready` is high, and `bus_cmd_valid` and `cpu_rsp_valid` are low.
- R2: A processor read that hits a valid line issues no bus command, returns the line data, and leaves the state unchanged.
- R3: A read miss issues a block-read command (opcode 0) carrying the request address. When it completes with `bus_shared_in` low, the line takes `bus_rdata`, the state becomes exclusive-clean (1), and the response returns `bus_rdata`.
- R4: A read miss that completes with `bus_shared_in` high leaves the line shared (2).
- R5: A write that hits an exclusive-clean or dirty line issues no bus command, stores the write data, and makes the state dirty (3).
- R6: A write that hits a shared line issues an update command (opcode 2) with address and write data. When it completes, the line holds the new data and stays shared (2).
- R7: A write miss issues a block-write command (opcode 1) with address and write data, and the line loads the write data. The state becomes exclusive-clean (1) if `bus_shared_in` is low at completion, or shared (2) if it is high.
- R8: A snooped block read (snoop opcode 0) that hits the valid line raises `snp_shared_out` and `snp_supply` in the same cycle, with `snp_rdata` equal to the line data. `snp_flush` is high only if the line was dirty. The state becomes shared.
- R9: A snooped block write (opcode 1) or update (opcode 2) that hits the valid line raises `snp_shared_out`, replaces the line data with `snp_data`, and leaves the state shared.
- R10: A snoop whose address differs from the tag, or that arrives while the line is invalid, raises no snoop output and changes neither state nor data.
- R11: `cpu_req_ready` is low in any cycle with `snp_valid`, so the snoop is applied first. A request presented with a snoop to the same line is served with the post-snoop data.
- R12: An unaccepted bus command and an unaccepted response hold all their fields stable, and `bus_done` never occurs together with `snp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Request accepted when high with valid |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Line address of the request |
| cpu_req_wdata | input | DW | Write data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Response accepted |
| cpu_rsp_rdata | output | DW | Read data or written value |
| bus_cmd_valid | output | 1 | Bus command pending |
| bus_cmd_ready | input | 1 | Bus grant for the pending command |
| bus_cmd_op | output | 2 | 0 block read, 1 block write, 2 update |
| bus_cmd_addr | output | AW | Command address |
| bus_cmd_data | output | DW | Command data (write and update) |
| bus_done | input | 1 | Granted command completed |
| bus_shared_in | input | 1 | Another cache holds the line (valid with bus_done) |
| bus_rdata | input | DW | Block data returned (valid with bus_done) |
| snp_valid | input | 1 | Snooped bus command present |
| snp_op | input | 2 | Snooped opcode, same coding as bus_cmd_op |
| snp_addr | input | AW | Snooped address |
| snp_data | input | DW | Snooped write or update data |
| snp_shared_out | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache drives the block data |
| snp_flush | output | 1 | Supplied data must also be written to memory |
| snp_rdata | output | DW | Supplied block data |
| line_st | output | 2 | Line state: 0 invalid, 1 exclusive-clean, 2 shared, 3 dirty |

## Verification
Directed sequences drive the line through every state and apply each processor and snoop operation to it. The main check is that a write hit in exclusive-clean or dirty stays off the bus, while the same write in shared produces an update. Another shows that completions with and without `bus_shared_in` separate exclusive-clean from shared fills. Snoops aimed at a non-matching address tell a real hit from a loose address compare. A snoop presented together with a request shows whether the snoop is applied first. Random mixes of requests and snoops over two addresses, with random grant and response stalls, compare every response, command and state against a bench model of the protocol.

// File: rtl/upd_coh_pkg.sv
`timescale 1ns/1ps
package upd_coh_pkg;
  typedef enum logic [1:0] {
    LS_INV    = 2'd0,
    LS_VEXCL  = 2'd1,
    LS_SHARED = 2'd2,
    LS_DIRTY  = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BOP_READ   = 2'd0,
    BOP_WRITE  = 2'd1,
    BOP_UPDATE = 2'd2,
    BOP_NONE   = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    ACT_READ_HIT,
    ACT_WRITE_LOCAL,
    ACT_BUS
  } proc_act_e;

  typedef enum logic [1:0] {
    F_IDLE,
    F_CMD,
    F_WAIT,
    F_RESP
  } fsm_e;
endpackage

// File: rtl/upd_coh_proc_dec.sv
`timescale 1ns/1ps
module upd_coh_proc_dec
  import upd_coh_pkg::*;
(
  input  line_st_e  st,
  input  logic      hit,
  input  logic      is_write,
  input  bus_op_e   done_op,
  input  logic      shared_in,
  output proc_act_e act,
  output bus_op_e   op,
  output line_st_e  fill_st
);
  // Classify a processor request against the current line.
  always_comb begin
    act = ACT_READ_HIT;
    op  = BOP_NONE;
    if (!hit) begin
      act = ACT_BUS;
      op  = is_write ? BOP_WRITE : BOP_READ;
    end else if (is_write) begin
      if (st == LS_SHARED) begin
        act = ACT_BUS;
        op  = BOP_UPDATE;
      end else begin
        act = ACT_WRITE_LOCAL;
      end
    end
  end

  // State taken when a bus transaction of this cache completes.
  always_comb begin
    if (done_op == BOP_UPDATE) fill_st = LS_SHARED;
    else                       fill_st = shared_in ? LS_SHARED : LS_VEXCL;
  end
endmodule

// File: rtl/upd_coh_snoop.sv
`timescale 1ns/1ps
module upd_coh_snoop
  import upd_coh_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          snp_valid,
  input  logic [1:0]    snp_op,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data,
  input  line_st_e      st,
  input  logic [AW-1:0] tag,
  input  logic [DW-1:0] data,
  output logic          hit,
  output logic          supply,
  output logic          flush,
  output logic [DW-1:0] rdata,
  output logic          upd_en,
  output logic [DW-1:0] nxt_data
);
  always_comb begin
    hit      = snp_valid && (st != LS_INV) && (tag == snp_addr) && (snp_op != BOP_NONE);
    supply   = hit && (snp_op == BOP_READ);
    flush    = supply && (st == LS_DIRTY);
    rdata    = supply ? data : '0;
    upd_en   = hit;
    nxt_data = (snp_op == BOP_READ) ? data : snp_data;
  end
endmodule

// File: rtl/upd_coh_line.sv
`timescale 1ns/1ps
module upd_coh_line
  import upd_coh_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_req_write,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_rsp_valid,
  input  logic          cpu_rsp_ready,
  output logic [DW-1:0] cpu_rsp_rdata,
  output logic          bus_cmd_valid,
  input  logic          bus_cmd_ready,
  output logic [1:0]    bus_cmd_op,
  output logic [AW-1:0] bus_cmd_addr,
  output logic [DW-1:0] bus_cmd_data,
  input  logic          bus_done,
  input  logic          bus_shared_in,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic [1:0]    snp_op,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data,
  output logic          snp_shared_out,
  output logic          snp_supply,
  output logic          snp_flush,
  output logic [DW-1:0] snp_rdata,
  output logic [1:0]    line_st
);
  fsm_e          fsm;
  line_st_e      st;
  logic [AW-1:0] tag;
  logic [DW-1:0] data;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  bus_op_e       pend_op;
  logic [DW-1:0] rsp_data;

  logic          cpu_hit;
  logic          accept;
  logic          own_done;
  proc_act_e     act;
  bus_op_e       dec_op;
  line_st_e      fill_st;
  logic          snp_upd_en;
  logic [DW-1:0] snp_nxt_data;

  assign cpu_hit       = (st != LS_INV) && (tag == cpu_req_addr);
  assign cpu_req_ready = (fsm == F_IDLE) && !snp_valid;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign own_done      = (fsm == F_WAIT) && bus_done;

  upd_coh_proc_dec u_dec (
    .st        (st),
    .hit       (cpu_hit),
    .is_write  (cpu_req_write),
    .done_op   (pend_op),
    .shared_in (bus_shared_in),
    .act       (act),
    .op        (dec_op),
    .fill_st   (fill_st)
  );

  upd_coh_snoop #(.AW(AW), .DW(DW)) u_snoop (
    .snp_valid (snp_valid),
    .snp_op    (snp_op),
    .snp_addr  (snp_addr),
    .snp_data  (snp_data),
    .st        (st),
    .tag       (tag),
    .data      (data),
    .hit       (snp_shared_out),
    .supply    (snp_supply),
    .flush     (snp_flush),
    .rdata     (snp_rdata),
    .upd_en    (snp_upd_en),
    .nxt_data  (snp_nxt_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= F_IDLE;
      st        <= LS_INV;
      tag       <= '0;
      data      <= '0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      pend_op   <= BOP_NONE;
      rsp_data  <= '0;
    end else begin
      // Snoop effect first; own completion below overrides it (never coincide).
      if (snp_upd_en) begin
        st   <= LS_SHARED;
        data <= snp_nxt_data;
      end
      case (fsm)
        F_IDLE: begin
          if (accept) begin
            req_write <= cpu_req_write;
            req_addr  <= cpu_req_addr;
            req_wdata <= cpu_req_wdata;
            case (act)
              ACT_READ_HIT: begin
                rsp_data <= data;
                fsm      <= F_RESP;
              end
              ACT_WRITE_LOCAL: begin
                data     <= cpu_req_wdata;
                st       <= LS_DIRTY;
                rsp_data <= cpu_req_wdata;
                fsm      <= F_RESP;
              end
              default: begin
                pend_op <= dec_op;
                fsm     <= F_CMD;
              end
            endcase
          end
        end
        F_CMD: begin
          if (bus_cmd_ready) fsm <= F_WAIT;
        end
        F_WAIT: begin
          if (own_done) begin
            tag <= req_addr;
            st  <= fill_st;
            if (pend_op == BOP_READ) begin
              data     <= bus_rdata;
              rsp_data <= bus_rdata;
            end else begin
              data     <= req_wdata;
              rsp_data <= req_wdata;
            end
            fsm <= F_RESP;
          end
        end
        default: begin
          if (cpu_rsp_ready) fsm <= F_IDLE;
        end
      endcase
    end
  end

  assign bus_cmd_valid = (fsm == F_CMD);
  assign bus_cmd_op    = pend_op;
  assign bus_cmd_addr  = req_addr;
  assign bus_cmd_data  = req_wdata;
  assign cpu_rsp_valid = (fsm == F_RESP);
  assign cpu_rsp_rdata = rsp_data;
  assign line_st       = st;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid && !bus_cmd_ready |=> bus_cmd_valid && $stable(bus_cmd_op) && $stable(bus_cmd_addr) && $stable(bus_cmd_data)); // R12
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata)); // R12
  AST_BUS_SNOOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_done && snp_valid)); // R12
  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_req_ready); // R11
  AST_LOCAL_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cpu_req_write && cpu_hit && (st == LS_VEXCL || st == LS_DIRTY)
    |=> line_st == LS_DIRTY && !bus_cmd_valid); // R5
  AST_UPDATE_STAYS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    own_done && pend_op == BOP_UPDATE |=> line_st == LS_SHARED); // R6
  AST_READ_FILL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    own_done && pend_op == BOP_READ |=> cpu_rsp_valid && cpu_rsp_rdata == $past(bus_rdata)); // R3
  AST_SNOOP_READ_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply && !bus_done |=> line_st == LS_SHARED); // R8
  AST_FLUSH_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_supply && line_st == LS_DIRTY); // R8
endmodule

// File: tb/upd_coh_line_tb.sv
`timescale 1ns/1ps
module upd_coh_line_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req_valid, cpu_req_ready, cpu_req_write;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_rsp_valid, cpu_rsp_ready;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          bus_cmd_valid, bus_cmd_ready;
  logic [1:0]    bus_cmd_op;
  logic [AW-1:0] bus_cmd_addr;
  logic [DW-1:0] bus_cmd_data;
  logic          bus_done, bus_shared_in;
  logic [DW-1:0] bus_rdata;
  logic          snp_valid;
  logic [1:0]    snp_op;
  logic [AW-1:0] snp_addr;
  logic [DW-1:0] snp_data;
  logic          snp_shared_out, snp_supply, snp_flush;
  logic [DW-1:0] snp_rdata;
  logic [1:0]    line_st;

  int tests = 0;
  int fails = 0;

  // Bench model of the line
  logic [1:0]    ms = 2'd0;
  logic [AW-1:0] mtag = '0;
  logic [DW-1:0] mdata = '0;

  always #2.5 clk = ~clk;

  upd_coh_line #(.AW(AW), .DW(DW)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cpu_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                            input bit sh, input logic [DW-1:0] mrd, input int cdly, input int rdly);
    bit hit, bus;
    logic [1:0] op;
    logic [DW-1:0] exp_rsp;
    string tg;
    hit = (ms != 2'd0) && (mtag == a);
    bus = !hit || (wr && ms == 2'd2);
    op  = !hit ? (wr ? 2'd1 : 2'd0) : 2'd2;
    if (bus) tg = (op == 2'd0) ? (sh ? "R4" : "R3") : (op == 2'd1 ? "R7" : "R6");
    else     tg = wr ? "R5" : "R2";
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (bus) begin
      chk(tg, {31'd0, bus_cmd_valid}, 32'd1);
      chk(tg, {30'd0, bus_cmd_op}, {30'd0, op});
      chk(tg, {16'd0, bus_cmd_addr}, {16'd0, a});
      if (op != 2'd0) chk(tg, bus_cmd_data, wd);
      for (int i = 0; i < cdly; i++) begin
        @(posedge clk); @(negedge clk);
        chk("R12", {31'd0, bus_cmd_valid}, 32'd1);
        chk("R12", {14'd0, bus_cmd_op, bus_cmd_addr}, {14'd0, op, a});
      end
      bus_cmd_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_cmd_ready = 1'b0;
      chk(tg, {31'd0, bus_cmd_valid}, 32'd0);
      bus_done = 1'b1; bus_shared_in = sh; bus_rdata = mrd;
      @(posedge clk); @(negedge clk);
      bus_done = 1'b0; bus_shared_in = 1'b0;
      mtag = a;
      if (op == 2'd0) begin mdata = mrd; ms = sh ? 2'd2 : 2'd1; end
      else if (op == 2'd1) begin mdata = wd; ms = sh ? 2'd2 : 2'd1; end
      else begin mdata = wd; ms = 2'd2; end
    end else begin
      chk(tg, {31'd0, bus_cmd_valid}, 32'd0);
      if (wr) begin mdata = wd; ms = 2'd3; end
    end
    exp_rsp = mdata;
    chk(tg, {31'd0, cpu_rsp_valid}, 32'd1);
    chk(tg, cpu_rsp_rdata, exp_rsp);
    for (int i = 0; i < rdly; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R12", {31'd0, cpu_rsp_valid}, 32'd1);
      chk("R12", cpu_rsp_rdata, exp_rsp);
    end
    cpu_rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    cpu_rsp_ready = 1'b0;
    #1;
    chk(tg, {30'd0, line_st}, {30'd0, ms});
  endtask

  task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit hit;
    string tg;
    hit = (ms != 2'd0) && (mtag == a);
    tg = !hit ? "R10" : (op == 2'd0 ? "R8" : "R9");
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a; snp_data = d;
    #1;
    chk(tg, {31'd0, snp_shared_out}, {31'd0, hit});
    chk(tg, {31'd0, snp_supply}, {31'd0, hit && op == 2'd0});
    chk(tg, {31'd0, snp_flush}, {31'd0, hit && op == 2'd0 && ms == 2'd3});
    if (hit && op == 2'd0) chk(tg, snp_rdata, mdata);
    chk("R11", {31'd0, cpu_req_ready}, 32'd0);
    @(posedge clk); @(negedge clk);
    snp_valid = 1'b0;
    if (hit) begin
      ms = 2'd2;
      if (op != 2'd0) mdata = d;
    end
    #1;
    chk(tg, {30'd0, line_st}, {30'd0, ms});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = '0; cpu_req_wdata = '0;
    cpu_rsp_ready = 0; bus_cmd_ready = 0; bus_done = 0; bus_shared_in = 0; bus_rdata = '0;
    snp_valid = 0; snp_op = '0; snp_addr = '0; snp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", {30'd0, line_st}, 32'd0);
    chk("R1", {31'd0, cpu_req_ready}, 32'd1);
    chk("R1", {31'd0, bus_cmd_valid}, 32'd0);
    chk("R1", {31'd0, cpu_rsp_valid}, 32'd0);

    cpu_access(1'b0, 16'h0010, 32'h0, 1'b0, 32'hAAAA_0001, 0, 0); // R3 -> exclusive-clean
    cpu_access(1'b0, 16'h0010, 32'h0, 1'b0, 32'h0, 0, 1);         // R2 read hit
    cpu_access(1'b1, 16'h0010, 32'h1111_2222, 1'b0, 32'h0, 0, 0); // R5 from exclusive-clean
    cpu_access(1'b1, 16'h0010, 32'h3333_4444, 1'b0, 32'h0, 0, 0); // R5 from dirty
    snoop(2'd0, 16'h0010, 32'h0);                                 // R8 dirty supply + flush
    cpu_access(1'b1, 16'h0010, 32'h5555_6666, 1'b0, 32'h0, 2, 0); // R6 update, R12 stall
    snoop(2'd2, 16'h0010, 32'h7777_8888);                         // R9 update
    cpu_access(1'b0, 16'h0010, 32'h0, 1'b0, 32'h0, 0, 0);         // R9 data visible
    snoop(2'd1, 16'h0011, 32'hDEAD_BEEF);                         // R10 address miss
    cpu_access(1'b0, 16'h0010, 32'h0, 1'b0, 32'h0, 0, 0);         // R10 data unchanged
    cpu_access(1'b1, 16'h0011, 32'h0BAD_F00D, 1'b1, 32'h0, 1, 2); // R7 shared fill
    cpu_access(1'b1, 16'h0012, 32'h1234_5678, 1'b0, 32'h0, 0, 0); // R7 exclusive fill
    snoop(2'd0, 16'h0012, 32'h0);                                 // R8 clean supply, no flush
    cpu_access(1'b0, 16'h0013, 32'h0, 1'b1, 32'hCAFE_0013, 0, 0); // R4
    snoop(2'd1, 16'h0013, 32'h9999_0000);                         // R9 block write

    // R11: request and snoop presented together; snoop applied first
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 16'h0013;
    snp_valid = 1'b1; snp_op = 2'd2; snp_addr = 16'h0013; snp_data = 32'h0F0F_0F0F;
    #1;
    chk("R11", {31'd0, cpu_req_ready}, 32'd0);
    @(posedge clk); @(negedge clk);
    snp_valid = 1'b0;
    mdata = 32'h0F0F_0F0F; ms = 2'd2;
    #1;
    chk("R11", {31'd0, cpu_req_ready}, 32'd1);
    @(posedge clk); @(negedge clk);
    cpu_req_valid = 1'b0;
    chk("R11", {31'd0, cpu_rsp_valid}, 32'd1);
    chk("R11", cpu_rsp_rdata, 32'h0F0F_0F0F);
    cpu_rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    cpu_rsp_ready = 1'b0;

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = 16'h0020 + AW'($urandom % 2);
      if (($urandom % 10) < 6)
        cpu_access(1'($urandom % 2), a, $urandom, 1'($urandom % 2), $urandom,
                   int'($urandom % 3), int'($urandom % 3));
      else
        snoop(2'($urandom % 3), a, $urandom);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule